// File: doc/BRIEF.md
# Packet Radio Transmit Sequencer with Clear-Channel Backoff

This block carries one packet from an upstream client out through a packet radio. The client offers a destination address and a fixed-size payload. The block takes them with a ready/start handshake. It then asks a byte-level serial framer to open one session that writes the whole frame into the radio's transmit FIFO. Each byte of that session is a single request/done exchange. The frame starts at the length byte. The preamble and the start-of-frame delimiter are added by the radio and are never written.

Once the FIFO is loaded, the block samples the radio's clear-channel flag. If the air is busy, it waits a pseudo-random number of symbol periods and samples the flag again. When the air is clear, it issues the one-byte transmit strobe. It then watches the start-of-frame flag go high and return low, which marks the end of the transmission.

After every transmission, and also after reset, the block holds off for twelve symbol periods before it accepts new work. This gives the radio time to settle back into receive, and it makes sure that the clear-channel flag can be trusted on the next attempt. A symbol lasts 16 us, and the number of clock cycles per symbol is derived from the clock frequency parameter.

Top module: `tx_backoff_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `tx_ready` and `spi_req` are low. `tx_ready` first rises exactly 12 symbol periods after the first clock edge following reset release.
- R2: A packet is taken only on a clock edge where `tx_start` and `tx_ready` are both high. A `tx_start` pulse while `tx_ready` is low is dropped and starts no request.
- R3: The FIFO load is one session of 18 bytes, in this order: 0x3E (register access, write, transmit-FIFO address), the length 0x10, `own_addr`, `tx_dest`, payload bytes 0 to 11 (byte k is `tx_payload[8k+7:8k]`), then 0x00 and 0x00. `spi_first` is high on the first byte only, and `spi_last` is high on the last byte only.
- R4: Each request holds `spi_req` high with a stable `spi_byte` until the framer answers with `spi_done`. Exactly one byte is consumed per `spi_done`.
- R5: If `cca` is high on the sampling edge, the transmit strobe is requested in the second cycle after the edge that consumed the last load byte. The strobe is a one-byte session: `spi_byte` is 0x04, and `spi_first` and `spi_last` are both high.
- R6: The strobe is never requested while `cca` reads low. A low sample starts a backoff of 1 to 16 symbol periods, after which `cca` is sampled again. Counted from the edge that consumed the last load byte, a single backoff puts the strobe request 2 + 16·n cycles later with 1 ≤ n ≤ 16 (at 16 cycles per symbol).
- R7: From the acknowledged strobe until the transmission ends, `spi_req` stays low (the FIFO is not written during a transmission) and `tx_ready` stays low. This holds both before `sfd` rises and while it is high.
- R8: A fall of `sfd` after its rise ends the transmission. `tx_ready` returns exactly 12 symbol periods after the edge that sees `sfd` low.
- R9: One symbol period is CLK_HZ/1,000,000 × 16 clock cycles, which is 16 cycles when CLK_HZ is 1 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 8 | Source address placed in the frame |
| tx_dest | input | 8 | Destination address (0xFF broadcast) |
| tx_payload | input | PAY_BYTES*8 | Payload, byte 0 in the low bits |
| tx_start | input | 1 | Client start, taken when tx_ready is high |
| tx_ready | output | 1 | Block idle and able to take a packet |
| spi_req | output | 1 | Byte request to the framer |
| spi_first | output | 1 | Request opens a framed session |
| spi_last | output | 1 | Request closes the framed session |
| spi_byte | output | 8 | Byte to send |
| spi_done | input | 1 | Framer has sent the requested byte |
| cca | input | 1 | Radio reports a clear channel |
| sfd | input | 1 | Radio start-of-frame flag |

## Verification
Every result is due a fixed number of edges after its stimulus. The next load byte appears on the edge that consumes `spi_done`. The strobe follows two edges after the last load byte when the channel is clear. `tx_ready` rises 192 edges (12 symbols of 16 cycles) after the edge that sees `sfd` low, and the same holds after reset release. The bench drives inputs and samples outputs on falling edges, counts those edges from the stimulus, and checks the output in exactly the cycle before and the cycle of the change. The one result it cannot predict is the pseudo-random backoff, so there it checks the window that R6 gives, plus the absence of a strobe for as long as the channel stays busy.

// File: rtl/txc_pkg.sv
package txc_pkg;

  // Frame opener for a transmit-FIFO write: register space, write, FIFO address
  localparam logic [7:0] FIFO_WR_HDR = 8'h3E;
  // Transmit strobe address
  localparam logic [7:0] STROBE_TX   = 8'h04;
  // Value written in place of the check sequence
  localparam logic [7:0] FCS_FILL    = 8'h00;

  typedef enum logic [3:0] {
    S_BOOT,
    S_GUARD,
    S_IDLE,
    S_LOAD,
    S_CCA,
    S_BACKOFF,
    S_STROBE,
    S_SFD_HI,
    S_SFD_LO
  } txc_state_t;

  // Clock cycles in one symbol period
  function automatic int ticks_per_symbol(input int clk_hz, input int sym_us);
    return (clk_hz / 1_000_000) * sym_us;
  endfunction

  // Length byte: source, destination, payload and two check bytes
  function automatic int mpdu_len(input int pay_bytes);
    return pay_bytes + 4;
  endfunction

  // Bytes in the FIFO-load session: opener, length byte, then the MPDU
  function automatic int load_bytes(input int pay_bytes);
    return mpdu_len(pay_bytes) + 2;
  endfunction

endpackage

// File: rtl/txc_lfsr.sv
module txc_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);

  logic [W-1:0] nxt;

  // Galois form: shift right, fold the tap mask in when the low bit is set
  always_comb begin
    nxt = {1'b0, state[W-1:1]};
    if (state[0]) nxt = nxt ^ TAPS[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED[W-1:0];
    else        state <= nxt;
  end

endmodule

// File: rtl/txc_symtimer.sv
module txc_symtimer #(
  parameter int TICKS = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_syms,
  output logic             expire,
  output logic             busy
);

  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [TW-1:0]    tick;
  logic [CNT_W-1:0] left;
  logic             active;
  logic             tick_wrap;

  assign tick_wrap = active && (tick == '0);
  // Fires in the final cycle of the last symbol: n_syms*TICKS edges after start
  assign expire    = tick_wrap && (left == CNT_W'(1));
  assign busy      = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick   <= '0;
      left   <= '0;
      active <= 1'b0;
    end else if (start) begin
      tick   <= TW'(TICKS - 1);
      left   <= n_syms;
      active <= 1'b1;
    end else if (tick_wrap) begin
      tick <= TW'(TICKS - 1);
      left <= left - CNT_W'(1);
      if (left == CNT_W'(1)) active <= 1'b0;
    end else if (active) begin
      tick <= tick - TW'(1);
    end
  end

endmodule

// File: rtl/txc_frame_sel.sv
module txc_frame_sel
  import txc_pkg::*;
#(
  parameter int PAY_BYTES = 12,
  parameter int IDX_W     = 5
) (
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             src,
  input  logic [7:0]             dst,
  input  logic [PAY_BYTES*8-1:0] payload,
  output logic [7:0]             byte_o
);

  localparam int          LEN_VAL = mpdu_len(PAY_BYTES);
  localparam logic [7:0]  LEN_B   = 8'(LEN_VAL);

  logic [7:0] pb [PAY_BYTES];

  for (genvar g = 0; g < PAY_BYTES; g++) begin : g_unpack
    assign pb[g] = payload[g*8 +: 8];
  end

  always_comb begin
    byte_o = FCS_FILL;
    if      (idx == IDX_W'(0)) byte_o = FIFO_WR_HDR;
    else if (idx == IDX_W'(1)) byte_o = LEN_B;
    else if (idx == IDX_W'(2)) byte_o = src;
    else if (idx == IDX_W'(3)) byte_o = dst;
    else begin
      for (int k = 0; k < PAY_BYTES; k++) begin
        if (idx == IDX_W'(k + 4)) byte_o = pb[k];
      end
    end
  end

endmodule

// File: rtl/tx_backoff_ctrl.sv
module tx_backoff_ctrl
  import txc_pkg::*;
#(
  parameter int          CLK_HZ     = 100_000_000,
  parameter int          SYM_US     = 16,
  parameter int          PAY_BYTES  = 12,
  parameter int          GUARD_SYMS = 12,
  parameter int          BO_LOG2    = 4,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             own_addr,
  input  logic [7:0]             tx_dest,
  input  logic [PAY_BYTES*8-1:0] tx_payload,
  input  logic                   tx_start,
  output logic                   tx_ready,
  output logic                   spi_req,
  output logic                   spi_first,
  output logic                   spi_last,
  output logic [7:0]             spi_byte,
  input  logic                   spi_done,
  input  logic                   cca,
  input  logic                   sfd
);

  localparam int TICKS  = ticks_per_symbol(CLK_HZ, SYM_US);
  localparam int NBYTES = load_bytes(PAY_BYTES);
  localparam int IDX_W  = $clog2(NBYTES);
  localparam int BO_MAX = 1 << BO_LOG2;
  localparam int SYM_W  = $clog2(((GUARD_SYMS > BO_MAX) ? GUARD_SYMS : BO_MAX) + 1);

  txc_state_t             state, state_nx;
  logic [IDX_W-1:0]       idx;
  logic [7:0]             src_q, dst_q;
  logic [PAY_BYTES*8-1:0] pay_q;
  logic [7:0]             load_byte;
  logic [15:0]            lfsr_q;
  logic [SYM_W-1:0]       backoff_syms;
  logic [SYM_W-1:0]       tmr_syms;
  logic                   tmr_start, tmr_done, tmr_busy;
  logic                   last_idx;

  // Named internal events, brought out for the checker
  logic ev_accept, ev_strobe, ev_backoff_start, ev_tx_end, in_air;

  txc_lfsr #(.W(16), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_q)
  );

  txc_symtimer #(.TICKS(TICKS), .CNT_W(SYM_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .n_syms (tmr_syms),
    .expire (tmr_done),
    .busy   (tmr_busy)
  );

  txc_frame_sel #(.PAY_BYTES(PAY_BYTES), .IDX_W(IDX_W)) u_sel (
    .idx     (idx),
    .src     (src_q),
    .dst     (dst_q),
    .payload (pay_q),
    .byte_o  (load_byte)
  );

  // Backoff drawn from the low LFSR bits: 1 .. 2**BO_LOG2 symbols
  assign backoff_syms = SYM_W'(lfsr_q[BO_LOG2-1:0]) + SYM_W'(1);

  assign last_idx         = (idx == IDX_W'(NBYTES - 1));
  assign ev_accept        = (state == S_IDLE) && tx_start;
  assign ev_strobe        = (state == S_STROBE);
  assign ev_backoff_start = (state == S_CCA) && !cca;
  assign ev_tx_end        = (state == S_SFD_LO) && !sfd;
  assign in_air           = (state == S_SFD_HI) || (state == S_SFD_LO);

  assign tmr_start = (state == S_BOOT) || ev_backoff_start || ev_tx_end;
  assign tmr_syms  = ev_backoff_start ? backoff_syms : SYM_W'(GUARD_SYMS);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_BOOT:    state_nx = S_GUARD;
      S_GUARD:   if (tmr_done) state_nx = S_IDLE;
      S_IDLE:    if (tx_start) state_nx = S_LOAD;
      S_LOAD:    if (spi_done && last_idx) state_nx = S_CCA;
      S_CCA:     state_nx = cca ? S_STROBE : S_BACKOFF;
      S_BACKOFF: if (tmr_done) state_nx = S_CCA;
      S_STROBE:  if (spi_done) state_nx = S_SFD_HI;
      S_SFD_HI:  if (sfd) state_nx = S_SFD_LO;
      S_SFD_LO:  if (!sfd) state_nx = S_GUARD;
      default:   state_nx = S_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_BOOT;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      src_q <= '0;
      dst_q <= '0;
      pay_q <= '0;
    end else begin
      if (ev_accept) begin
        idx   <= '0;
        src_q <= own_addr;
        dst_q <= tx_dest;
        pay_q <= tx_payload;
      end else if ((state == S_LOAD) && spi_done && !last_idx) begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  assign tx_ready  = (state == S_IDLE);
  assign spi_req   = (state == S_LOAD) || ev_strobe;
  assign spi_byte  = ev_strobe ? STROBE_TX : load_byte;
  assign spi_first = ev_strobe || ((state == S_LOAD) && (idx == '0));
  assign spi_last  = ev_strobe || ((state == S_LOAD) && last_idx);

endmodule

// File: rtl/tx_backoff_ctrl_chk.sv
module tx_backoff_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_ready,
  input logic       spi_req,
  input logic       spi_first,
  input logic [7:0] spi_byte,
  input logic       spi_done,
  input logic       cca,
  input logic       ev_strobe,
  input logic       in_air,
  input logic       ev_tx_end
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_done) |=> (spi_req && $stable(spi_byte))); // R4

  AST_NO_LOAD_IN_AIR: assert property (@(posedge clk) disable iff (!rst_n)
    in_air |-> !spi_req); // R7

  AST_STROBE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_strobe) |-> $past(cca)); // R5

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !spi_req); // R2

  AST_OPEN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && spi_first && !ev_strobe) |-> (spi_byte == 8'h3E)); // R3

  AST_GUARD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_end |=> (!tx_ready && !spi_req)); // R8

endmodule

bind tx_backoff_ctrl tx_backoff_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_ready  (tx_ready),
  .spi_req   (spi_req),
  .spi_first (spi_first),
  .spi_byte  (spi_byte),
  .spi_done  (spi_done),
  .cca       (cca),
  .ev_strobe (ev_strobe),
  .in_air    (in_air),
  .ev_tx_end (ev_tx_end)
);

// File: tb/tb_tx_backoff_ctrl.sv
module tb_tx_backoff_ctrl;

  localparam int PAY    = 12;
  localparam int SYM    = 16;          // cycles per symbol at 1 MHz (R9)
  localparam int GUARD  = 12 * SYM;    // 192 edges
  localparam int NBYTES = PAY + 6;

  // {dest, payload base, payload step}
  localparam logic [23:0] VEC [5] = '{
    {8'h42, 8'h00, 8'h01},
    {8'hFF, 8'hA5, 8'h11},
    {8'h07, 8'hF0, 8'hFF},
    {8'h99, 8'h3C, 8'h00},
    {8'h01, 8'h80, 8'h07}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [7:0]       own_addr;
  logic [7:0]       tx_dest;
  logic [PAY*8-1:0] tx_payload;
  logic             tx_start;
  logic             tx_ready;
  logic             spi_req, spi_first, spi_last;
  logic [7:0]       spi_byte;
  logic             spi_done;
  logic             cca, sfd;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  tx_backoff_ctrl #(.CLK_HZ(1_000_000)) dut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .tx_dest(tx_dest),
    .tx_payload(tx_payload), .tx_start(tx_start), .tx_ready(tx_ready),
    .spi_req(spi_req), .spi_first(spi_first), .spi_last(spi_last),
    .spi_byte(spi_byte), .spi_done(spi_done), .cca(cca), .sfd(sfd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150_000; c++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles, expected completion", 150_000);
    finish_run();
  end

  function automatic logic [7:0] exp_byte(input int i, input logic [7:0] dst,
                                          input logic [7:0] base, input logic [7:0] step);
    if (i == 0) return 8'h3E;
    if (i == 1) return 8'h10;
    if (i == 2) return own_addr;
    if (i == 3) return dst;
    if (i < 4 + PAY) return 8'(base + 8'(i - 4) * step);
    return 8'h00;
  endfunction

  task automatic serve(input int hold, output logic [7:0] b, output logic f,
                       output logic l, output bit held_ok);
    while (!spi_req) @(negedge clk);
    b = spi_byte; f = spi_first; l = spi_last; held_ok = 1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!spi_req || spi_byte != b) held_ok = 0;
    end
    spi_done = 1'b1;
    @(negedge clk);
    spi_done = 1'b0;
  endtask

  // mode 0: clear channel, 1: short busy, 2: long busy
  task automatic send(input logic [7:0] dst, input logic [7:0] base,
                      input logic [7:0] step, input int mode);
    logic [7:0] b;
    logic       f, l;
    bit         held, bytes_ok, flags_ok, quiet;
    int         bad_i, m;
    while (!tx_ready) @(negedge clk);
    tx_dest = dst;
    for (int k = 0; k < PAY; k++) tx_payload[k*8 +: 8] = 8'(base + 8'(k) * step);
    cca      = (mode == 0);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    bytes_ok = 1; flags_ok = 1; bad_i = -1;
    for (int i = 0; i < NBYTES; i++) begin
      serve((i == 0) ? 3 : 0, b, f, l, held);
      if (i == 0) chk(held, "R4 request held until done", int'(held), 1);
      if (b != exp_byte(i, dst, base, step)) begin
        if (bytes_ok) bad_i = i;
        bytes_ok = 0;
      end
      if (f != (i == 0) || l != (i == NBYTES - 1)) flags_ok = 0;
    end
    chk(bytes_ok, "R3 load byte order", bad_i, -1);
    chk(flags_ok, "R3 session first/last flags", int'(flags_ok), 1);
    // now just after edge L that consumed the last byte
    if (mode == 0) begin
      chk(!spi_req, "R5 no strobe one cycle after load", int'(spi_req), 0);
      @(negedge clk);
      chk(spi_req && spi_byte == 8'h04, "R5 strobe second cycle", int'(spi_byte), 4);
    end else if (mode == 1) begin
      @(negedge clk);
      cca = 1'b1;
      m = 1;
      while (!spi_req) begin @(negedge clk); m++; end
      chk(m >= 2 + SYM && m <= 2 + 16 * SYM, "R6 backoff window", m, 2 + SYM);
    end else begin
      quiet = 1;
      for (int c = 0; c < 600; c++) begin
        @(negedge clk);
        if (spi_req) quiet = 0;
      end
      chk(quiet, "R6 no strobe while busy", int'(quiet), 1);
      cca = 1'b1;
      m = 0;
      while (!spi_req) begin @(negedge clk); m++; end
      chk(m <= 2 + 16 * SYM, "R6 strobe after clear", m, 2 + 16 * SYM);
    end
    chk(spi_first && spi_last && spi_byte == 8'h04, "R5 strobe single-byte session",
        int'({spi_first, spi_last}), 3);
    serve(0, b, f, l, held);
    quiet = 1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (spi_req || tx_ready) quiet = 0;
    end
    sfd = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (spi_req || tx_ready) quiet = 0;
    end
    chk(quiet, "R7 quiet during transmission", int'(quiet), 1);
    sfd = 1'b0;
    for (int c = 0; c < GUARD; c++) @(negedge clk);
    chk(!tx_ready, "R8 R9 guard still running", int'(tx_ready), 0);
    @(negedge clk);
    chk(tx_ready, "R8 R9 ready after 12 symbols", int'(tx_ready), 1);
  endtask

  initial begin
    bit quiet;
    rst_n = 1'b0; own_addr = 8'h21; tx_dest = '0; tx_payload = '0;
    tx_start = 1'b0; spi_done = 1'b0; cca = 1'b1; sfd = 1'b0;
    for (int c = 0; c < 4; c++) @(negedge clk);
    chk(!tx_ready && !spi_req, "R1 reset outputs", int'({tx_ready, spi_req}), 0);
    rst_n = 1'b1;
    quiet = 1;
    for (int k = 1; k <= GUARD; k++) begin
      tx_start = (k == 100);
      @(negedge clk);
      if (spi_req) quiet = 0;
    end
    tx_start = 1'b0;
    chk(quiet, "R2 start ignored while not ready", int'(quiet), 1);
    chk(!tx_ready, "R1 settle before ready", int'(tx_ready), 0);
    @(negedge clk);
    chk(tx_ready, "R1 ready after settle", int'(tx_ready), 1);

    for (int v = 0; v < 5; v++)
      send(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 0);

    send(8'h55, 8'h10, 8'h03, 1);
    send(8'hFF, 8'hC3, 8'h05, 2);
    finish_run();
  end

endmodule